// File: doc/BRIEF.md
# Cascaded BCD Event Counter with Holding Register

This block counts events in packed decimal. Six internal BCD decades form the upper part of an eight-digit number. The two lowest digits come from outside, normally from a faster prescaler that is built in a separate stage. The count event is the falling edge of the OR of two count inputs. A prescaler can therefore drive the block through its own top bits, or a plain pulse source can drive one input while the other is held low.

A sticky overflow flag records the first falling edge on a separate overflow input. The tapped decade MSB outputs can be wired back into that input. An eight-digit holding register, plus one bit for the overflow flag, follows the live count while the active-low load input is low and freezes while it is high. This lets downstream logic read a steady value while counting goes on.

All logic runs on one system clock. The count, overflow, clear and load inputs pass through two-stage synchronizers. Each one counts as at most one event per clock.

Top module: `bcd_count_latch`

## Requirements
- R1: Each falling edge of the combined count signal adds one to the six-decade value. The decades carry in decimal. Held digit i (i = 2..7) is `held_bcd[4*i+3:4*i]`, and digit 2 is the least significant internal decade.
- R2: The combined count signal is `cnt_a | cnt_b`. A falling edge on one input while the other is high produces no count.
- R3: When every internal decade reads 9, the next count event returns all of them to 0.
- R4: While `clear_n` is low, all internal decades and the overflow flag are forced to zero. They stay zero after release until new events arrive.
- R5: The overflow flag sets on the first falling edge of `ovf_in` after a clear. It stays set through later edges of `ovf_in` until the next clear.
- R6: Held digits 0 and 1 (`held_bcd[7:0]`) take `ext_bcd[7:0]`, with digit 0 in the low nibble.
- R7: While `load_n` is low, `held_bcd` and `held_ovf` follow the live digits and the overflow flag. While `load_n` is high, both keep their last value.
- R8: `top_msb[k]` is bit 3 of internal decade 3+k, that is digit positions 5, 6 and 7 of the eight-digit number.
- R9: A count or overflow edge that arrives while a clear is in effect is discarded. The clear wins.
- R10: No internal decade ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear_n | input | 1 | Active-low clear of the decades and the overflow flag |
| cnt_a | input | 1 | Count input, ORed with cnt_b |
| cnt_b | input | 1 | Count input, ORed with cnt_a |
| ovf_in | input | 1 | Overflow event input, falling-edge sensitive |
| load_n | input | 1 | Low: holding register follows. High: holds |
| ext_bcd | input | 8 | Two external BCD digits, digit 0 in bits 3:0 |
| held_bcd | output | 32 | Held eight-digit BCD value |
| held_ovf | output | 1 | Held overflow flag |
| top_msb | output | 3 | MSBs of the three most significant internal decades |

## Verification
A clear and a count edge (or an overflow edge) can land in the same cycle. The bench provokes this by dropping `clear_n`, `cnt_a` and `ovf_in` on the same clock edge. Both edge inputs were held high beforehand, so a real falling edge reaches the synchronizers. After release it expects every internal digit and the held overflow flag to read zero. A second overlap joins a count edge on one input with the other input held high; here the held value is judged unchanged.

// File: rtl/bcd_count_pkg.sv
package bcd_count_pkg;
   typedef logic [3:0] bcd_t;

   localparam bcd_t BCD_MAX = 4'd9;

   function automatic bcd_t bcd_step(input bcd_t v);
      return (v >= BCD_MAX) ? 4'd0 : v + 4'd1;
   endfunction
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("bcd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
   import bcd_count_pkg::*;
(
   input  logic clk,
   input  logic clr,
   input  logic inc_in,
   output bcd_t digit,
   output logic inc_out
);
   always_ff @(posedge clk) begin
      if (clr)         digit <= 4'd0;
      else if (inc_in) digit <= bcd_step(digit);
   end

   assign inc_out = inc_in && (digit == BCD_MAX);
endmodule

// File: rtl/bcd_hold_bank.sv
module bcd_hold_bank #(
   parameter int W = 33
) (
   input  logic         clk,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!hold) q <= d;
   end
endmodule

// File: rtl/bcd_count_latch.sv
module bcd_count_latch
   import bcd_count_pkg::*;
#(
   parameter int N_DEC  = 6,
   parameter int N_EXT  = 2,
   parameter int N_TAP  = 3,
   parameter int STAGES = 2
) (
   input  logic                       clk,
   input  logic                       clear_n,
   input  logic                       cnt_a,
   input  logic                       cnt_b,
   input  logic                       ovf_in,
   input  logic                       load_n,
   input  logic [4*N_EXT-1:0]         ext_bcd,
   output logic [4*(N_DEC+N_EXT)-1:0] held_bcd,
   output logic                       held_ovf,
   output logic [N_TAP-1:0]           top_msb
);
   localparam int N_DIG  = N_DEC + N_EXT;
   localparam int W_DIG  = 4 * N_DIG;
   localparam int W_HOLD = W_DIG + 1;

   generate
      if (N_DEC < 1)     begin : g_bad_dec  $error("N_DEC must be >= 1");        end
      if (N_EXT < 0)     begin : g_bad_ext  $error("N_EXT must be >= 0");        end
      if (N_TAP < 1 || N_TAP > N_DEC)
                         begin : g_bad_tap  $error("N_TAP must be 1..N_DEC");    end
      if (STAGES < 2)    begin : g_bad_sync $error("STAGES must be >= 2");       end
   endgenerate

   // synchronized controls
   logic rst_q, load_s, cnt_s, ovf_s;
   logic cnt_prev, ovf_prev;
   logic cnt_fall, ovf_fall;

   bcd_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk(clk), .arst_n(clear_n), .d(1'b1), .q(rst_q));

   bcd_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_cnt_sync (
      .clk(clk), .arst_n(clear_n), .d(cnt_a | cnt_b), .q(cnt_s));

   bcd_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ovf_sync (
      .clk(clk), .arst_n(clear_n), .d(ovf_in), .q(ovf_s));

   bcd_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_load_sync (
      .clk(clk), .arst_n(1'b1), .d(load_n), .q(load_s));

   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n) begin
         cnt_prev <= 1'b0;
         ovf_prev <= 1'b0;
      end else begin
         cnt_prev <= cnt_s;
         ovf_prev <= ovf_s;
      end
   end

   assign cnt_fall = cnt_prev & ~cnt_s;
   assign ovf_fall = ovf_prev & ~ovf_s;

   // decade chain
   logic [N_DEC:0]     carry;
   logic [4*N_DEC-1:0] dec_flat;

   assign carry[0] = cnt_fall;

   generate
      for (genvar i = 0; i < N_DEC; i++) begin : g_dec
         bcd_t dig;
         bcd_decade u_dec (
            .clk    (clk),
            .clr    (~rst_q),
            .inc_in (carry[i]),
            .digit  (dig),
            .inc_out(carry[i+1]));
         assign dec_flat[4*i +: 4] = dig;
      end
   endgenerate

   // overflow flip-flop
   logic ovf_ff;

   always_ff @(posedge clk) begin
      if (!rst_q)        ovf_ff <= 1'b0;
      else if (ovf_fall) ovf_ff <= 1'b1;
   end

   // holding register: overflow bit on top, then decades, then external
   logic [W_HOLD-1:0] hold_q;

   bcd_hold_bank #(.W(W_HOLD)) u_hold (
      .clk (clk),
      .hold(load_s),
      .d   ({ovf_ff, dec_flat, ext_bcd}),
      .q   (hold_q));

   assign held_bcd = hold_q[W_DIG-1:0];
   assign held_ovf = hold_q[W_DIG];

   generate
      for (genvar t = 0; t < N_TAP; t++) begin : g_tap
         assign top_msb[t] = dec_flat[4*(N_DEC-N_TAP+t)+3];
      end
   endgenerate

   // carry out of the top decade has no consumer; wrap is implicit
   logic carry_top_unused;
   assign carry_top_unused = carry[N_DEC];
endmodule

// File: rtl/bcd_count_latch_chk.sv
module bcd_count_latch_chk #(
   parameter int N_DEC = 6,
   parameter int W_DIG = 32
) (
   input logic               clk,
   input logic               clear_n,
   input logic               rst_q,
   input logic               cnt_fall,
   input logic               load_s,
   input logic [4*N_DEC-1:0] dec_flat,
   input logic               ovf_ff,
   input logic [W_DIG-1:0]   held_bcd,
   input logic               held_ovf
);
   // R4
   clear_zero_chk: assert property (@(posedge clk) disable iff (!clear_n)
      !rst_q |=> (dec_flat == '0) && !ovf_ff);

   // R1
   no_edge_stable_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rst_q && !cnt_fall) |=> $stable(dec_flat));

   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!clear_n)
      (rst_q && ovf_ff) |=> ovf_ff);

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!clear_n)
      load_s |=> ($stable(held_bcd) && $stable(held_ovf)));

   // R10
   always_comb begin
      for (int i = 0; i < N_DEC; i++) begin
         decade_range_chk: assert (!clear_n || dec_flat[4*i +: 4] <= 4'd9);
      end
   end
endmodule

bind bcd_count_latch bcd_count_latch_chk #(.N_DEC(N_DEC), .W_DIG(W_DIG)) u_chk (
   .clk     (clk),
   .clear_n (clear_n),
   .rst_q   (rst_q),
   .cnt_fall(cnt_fall),
   .load_s  (load_s),
   .dec_flat(dec_flat),
   .ovf_ff  (ovf_ff),
   .held_bcd(held_bcd),
   .held_ovf(held_ovf));

// File: tb/tb_bcd_count_latch.sv
module tb_bcd_count_latch;
   logic        clk = 1'b0;
   logic        clear_n = 1'b0;
   logic        cnt_a = 1'b0, cnt_b = 1'b0, ovf_in = 1'b0, load_n = 1'b0;
   logic [7:0]  ext_bcd = 8'h00;
   logic [31:0] held_bcd;
   logic        held_ovf;
   logic [2:0]  top_msb;

   logic        cnt2 = 1'b0;
   logic [15:0] held2;
   logic        ovf2;
   logic [0:0]  msb2;

   int n_chk = 0, n_bad = 0;
   int exp_cnt = 0;

   always #2.5 clk = ~clk;

   bcd_count_latch dut (
      .clk(clk), .clear_n(clear_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
      .ovf_in(ovf_in), .load_n(load_n), .ext_bcd(ext_bcd),
      .held_bcd(held_bcd), .held_ovf(held_ovf), .top_msb(top_msb));

   bcd_count_latch #(.N_DEC(2), .N_EXT(2), .N_TAP(1)) wrap_dut (
      .clk(clk), .clear_n(clear_n), .cnt_a(cnt2), .cnt_b(1'b0),
      .ovf_in(1'b0), .load_n(load_n), .ext_bcd(8'h00),
      .held_bcd(held2), .held_ovf(ovf2), .top_msb(msb2));

   function automatic logic [23:0] to_bcd(input int v);
      logic [23:0] r;
      int x;
      x = v;
      for (int i = 0; i < 6; i++) begin
         r[4*i +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_a(input int n);
      for (int i = 0; i < n; i++) begin
         cnt_a = 1'b1; wait_n(2);
         cnt_a = 1'b0; wait_n(2);
      end
      wait_n(4);
   endtask

   task automatic pulse_b(input int n);
      for (int i = 0; i < n; i++) begin
         cnt_b = 1'b1; wait_n(2);
         cnt_b = 1'b0; wait_n(2);
      end
      wait_n(4);
   endtask

   task automatic do_clear();
      clear_n = 1'b0; wait_n(3);
      clear_n = 1'b1; wait_n(6);
      exp_cnt = 0;
   endtask

   task automatic t_reset();
      do_clear();
      check("R4 digits", held_bcd, 32'h0);
      check("R4 ovf", {31'b0, held_ovf}, 32'h0);
   endtask

   task automatic t_count_a();
      pulse_a(7); exp_cnt += 7;
      check("R1 count a", {8'h0, held_bcd[31:8]}, {8'h0, to_bcd(exp_cnt)});
      pulse_a(9); exp_cnt += 9;
      check("R1 carry", {8'h0, held_bcd[31:8]}, {8'h0, to_bcd(exp_cnt)});
   endtask

   task automatic t_count_b();
      pulse_b(5); exp_cnt += 5;
      check("R2 count b", {8'h0, held_bcd[31:8]}, {8'h0, to_bcd(exp_cnt)});
   endtask

   task automatic t_or_mask();
      cnt_a = 1'b1; wait_n(3);
      pulse_b(4);
      cnt_a = 1'b0; wait_n(6); exp_cnt += 1;
      check("R2 or mask", {8'h0, held_bcd[31:8]}, {8'h0, to_bcd(exp_cnt)});
   endtask

   task automatic t_ext();
      ext_bcd = 8'h93; wait_n(6);
      check("R6 ext", {24'h0, held_bcd[7:0]}, 32'h93);
      ext_bcd = 8'h05; wait_n(6);
      check("R6 ext2", {24'h0, held_bcd[7:0]}, 32'h05);
   endtask

   task automatic t_hold();
      logic [31:0] snap;
      snap = held_bcd;
      load_n = 1'b1; wait_n(4);
      pulse_a(3); exp_cnt += 3;
      ext_bcd = 8'h71; ovf_in = 1'b1; wait_n(3); ovf_in = 1'b0; wait_n(6);
      check("R7 hold digits", held_bcd, snap);
      check("R7 hold ovf", {31'b0, held_ovf}, 32'h0);
      load_n = 1'b0; wait_n(6);
      check("R7 follow", held_bcd, {to_bcd(exp_cnt), 8'h71});
      check("R5 first edge", {31'b0, held_ovf}, 32'h1);
   endtask

   task automatic t_ovf_sticky();
      ovf_in = 1'b1; wait_n(3); ovf_in = 1'b0; wait_n(3);
      ovf_in = 1'b1; wait_n(6);
      check("R5 sticky", {31'b0, held_ovf}, 32'h1);
      ovf_in = 1'b0; wait_n(3);
      do_clear();
      check("R4 ovf clear", {31'b0, held_ovf}, 32'h0);
   endtask

   task automatic t_clear_wins();
      pulse_a(4); exp_cnt += 4;
      cnt_a = 1'b1; ovf_in = 1'b1; wait_n(4);
      clear_n = 1'b0; cnt_a = 1'b0; ovf_in = 1'b0;
      wait_n(4);
      clear_n = 1'b1; wait_n(8);
      exp_cnt = 0;
      check("R9 count dropped", {8'h0, held_bcd[31:8]}, 32'h0);
      check("R9 ovf dropped", {31'b0, held_ovf}, 32'h0);
   endtask

   task automatic t_msb();
      do_clear();
      check("R8 msb zero", {29'b0, top_msb}, 32'h0);
      for (int i = 0; i < 8000; i++) begin
         cnt_a = 1'b1; wait_n(2);
         cnt_a = 1'b0; wait_n(2);
      end
      wait_n(6); exp_cnt = 8000;
      check("R1 8000", {8'h0, held_bcd[31:8]}, {8'h0, to_bcd(exp_cnt)});
      check("R8 msb d5", {29'b0, top_msb}, 32'h1);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 99; i++) begin
         cnt2 = 1'b1; wait_n(2);
         cnt2 = 1'b0; wait_n(2);
      end
      wait_n(6);
      check("R3 at 99", {16'h0, held2}, 32'h9900);
      check("R8 small msb", {31'b0, msb2}, 32'h1);
      cnt2 = 1'b1; wait_n(2); cnt2 = 1'b0; wait_n(8);
      check("R3 wrap", {16'h0, held2}, 32'h0000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait_n(2);
      t_reset();
      t_count_a();
      t_count_b();
      t_or_mask();
      t_ext();
      t_hold();
      t_ovf_sticky();
      t_clear_wins();
      t_msb();
      t_wrap();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule